// File: doc/BRIEF.md
# Universal Serial Shift Interface

This block is a low-level serial peripheral. It has one data shift register and one clock-edge counter, and both wire modes share them. In the three-wire mode it behaves as an SPI-style shifter. In the two-wire mode it provides the physical layer of an I2C-style bus, with open-drain data and clock pull-downs. Software sets the wire mode, the clock source and the shift edge through a small register port. The serial clock can come from two places:

- An external pin, when the block acts as a slave.
- A strobe input, when the block acts as a master. Software pulses the strobe to toggle the clock output.

Every clock edge advances the counter, and either edge can be chosen as the shift edge. One byte takes 16 edges, so the counter overflow marks the end of a transfer. No byte-level protocol engine is involved.

In the two-wire slave mode the block stretches SCL. It holds the line low after a start condition or after a counter overflow, until software clears the matching flag. Software uses these wait states to prepare the next byte. External inputs pass through two-flop synchronizers, and edges are detected in the system clock domain.

Top module: `ussi_core`

## Requirements
- R1: After reset the control, data and status registers read 0 and all pin outputs (`do_o`, `sck_o`, `scl_low_o`, `sda_low_o`) are 0.
- R2: In three-wire mode (control bits [1:0] = 01) `do_o` shows the data register MSB. On each shift edge the register shifts left and takes the synchronized `di_i` into its LSB.
- R3: Every edge of the selected clock, rising or falling, increments the counter in status bits [3:0]. After 16 edges from 0 the counter wraps to 0 and sets the overflow flag (status bit 7).
- R4: A write to the status register loads the counter from write data bits [3:0]. Bit 7 = 1 in the write clears the overflow flag, and bit 6 = 1 clears the start flag.
- R5: In an external-clock three-wire transfer of 16 edges, the byte held before the transfer leaves MSB first. Afterwards the data register holds the byte that was received.
- R6: In two-wire mode (control bits [1:0] = 10) `sda_low_o` is 1 exactly when the data register MSB is 0.
- R7: In two-wire mode with external clock, `scl_low_o` is 1 while the overflow flag is set, and is released once the flag is cleared.
- R8: In two-wire mode, a falling SDA while SCL is high sets the start flag (status bit 6). While the flag is set in slave mode, `scl_low_o` is held.
- R9: With control bit 2 = 1 (software clock), each `sw_strobe` pulse toggles the clock level on `sck_o` and counts as one clock edge. A toggle to high is a rising edge.
- R10: With control bits [1:0] = 00 the clock pin is ignored: counter and data register do not change.
- R11: Control bit 3 selects the shift edge. 0 shifts on rising edges and 1 shifts on falling edges; both edges still count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sw_strobe | input | 1 | Software clock toggle pulse |
| sck_i | input | 1 | Serial clock pin (SCK or SCL) level |
| di_i | input | 1 | Three-wire data input pin |
| sda_i | input | 1 | Two-wire data line level |
| do_o | output | 1 | Three-wire data output |
| sck_o | output | 1 | Three-wire software-generated clock output |
| scl_low_o | output | 1 | Pull SCL low (open-drain) |
| sda_low_o | output | 1 | Pull SDA low (open-drain) |

## Verification
A wrong counter value shows at the status port within three system cycles of a pin edge. It also moves the overflow by whole edges, so the byte received at the end of a transfer comes out shifted and the SCL hold starts early or late. A corrupted shift register appears on `do_o` or `sda_low_o` before the next shift edge. A missed start or overflow flag shows as SCL released when it should be held. The bench runs random bytes through the shifter with each clock source and compares every bit on the wire against a bench model.

// File: rtl/ussi_pkg.sv
package ussi_pkg;
   typedef enum logic [1:0] {
      WM_OFF   = 2'b00,
      WM_THREE = 2'b01,
      WM_TWO   = 2'b10,
      WM_RSVD  = 2'b11
   } wire_mode_e;

   typedef struct packed {
      logic       shift_neg;
      logic       clk_sw;
      wire_mode_e mode;
   } ctrl_t;

   localparam int CTRL_W = 4;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_DATA = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;
endpackage

// File: rtl/ussi_sync.sv
module ussi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ussi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/ussi_clkgen.sv
module ussi_clkgen (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clk_sw,
   input  logic shift_neg,
   input  logic strobe,
   input  logic pin_s,
   output logic edge_o,
   output logic shift_o,
   output logic sck_lvl_o
);
   logic pin_prev;
   logic sck_lvl;
   logic is_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     sck_lvl <= 1'b0;
      else if (en && clk_sw && strobe) sck_lvl <= ~sck_lvl;
   end

   always_comb begin
      if (clk_sw) begin
         edge_o  = en & strobe;
         is_rise = ~sck_lvl;
      end else begin
         edge_o  = en & (pin_s ^ pin_prev);
         is_rise = pin_s & ~pin_prev;
      end
      shift_o = edge_o & (shift_neg ? ~is_rise : is_rise);
   end

   assign sck_lvl_o = sck_lvl;

   p_sw_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clk_sw && strobe) |=> (sck_lvl != $past(sck_lvl)));
endmodule

// File: rtl/ussi_cnt.sv
module ussi_cnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          edge_i,
   input  logic          wr,
   input  logic [CW-1:0] wr_cnt,
   input  logic          wr_clr,
   output logic [CW-1:0] cnt_o,
   output logic          ovf_o
);
   logic [CW-1:0] cnt;
   logic          ovf;
   logic          wrap;

   assign wrap = edge_i & ~wr & (cnt == {CW{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (wr)     cnt <= wr_cnt;
      else if (edge_i) cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ovf <= 1'b0;
      else if (wrap)           ovf <= 1'b1;
      else if (wr && wr_clr)   ovf <= 1'b0;
   end

   assign cnt_o = cnt;
   assign ovf_o = ovf;

   p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && !wr && cnt == {CW{1'b1}}) |=> (ovf && cnt == '0));
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && !wr) |=> (cnt == $past(cnt) + 1'b1));
   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (cnt == $past(wr_cnt)));
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wr_clr) |=> !ovf);
endmodule

// File: rtl/ussi_core.sv
module ussi_core #(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          sw_strobe,
   input  logic          sck_i,
   input  logic          di_i,
   input  logic          sda_i,
   output logic          do_o,
   output logic          sck_o,
   output logic          scl_low_o,
   output logic          sda_low_o
);
   import ussi_pkg::*;

   localparam int CW     = $clog2(2 * DW);
   localparam int PAD_ST = DW - 2 - CW;
   localparam int PAD_CT = DW - CTRL_W;

   if (DW < 8 || DW > 32 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("ussi_core: DW must be a power of two from 8 to 32");
   end

   ctrl_t         ctrl;
   logic [DW-1:0] sr;
   logic          start_f;
   logic          sck_s, di_s, sda_s, sda_prev;
   logic          three, two, en;
   logic          edge_e, shift_e, sck_lvl;
   logic [CW-1:0] cnt;
   logic          ovf;
   logic          din, sda_fall;
   logic          ctrl_wr, data_wr, stat_wr;

   assign ctrl_wr = reg_wr && reg_addr == A_CTRL;
   assign data_wr = reg_wr && reg_addr == A_DATA;
   assign stat_wr = reg_wr && reg_addr == A_STAT;

   ussi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
   ussi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_di (
      .clk(clk), .rst_n(rst_n), .d(di_i), .q(di_s));
   ussi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl <= '0;
      else if (ctrl_wr) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
   end

   assign three = ctrl.mode == WM_THREE;
   assign two   = ctrl.mode == WM_TWO;
   assign en    = three | two;
   assign din   = two ? sda_s : di_s;

   ussi_clkgen u_clkgen (
      .clk(clk), .rst_n(rst_n), .en(en), .clk_sw(ctrl.clk_sw),
      .shift_neg(ctrl.shift_neg), .strobe(sw_strobe), .pin_s(sck_s),
      .edge_o(edge_e), .shift_o(shift_e), .sck_lvl_o(sck_lvl));

   ussi_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .edge_i(edge_e), .wr(stat_wr),
      .wr_cnt(reg_wdata[CW-1:0]), .wr_clr(reg_wdata[DW-1]),
      .cnt_o(cnt), .ovf_o(ovf));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr <= '0;
      else if (data_wr) sr <= reg_wdata;
      else if (shift_e) sr <= {sr[DW-2:0], din};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_prev <= 1'b1;
      else        sda_prev <= sda_s;
   end
   assign sda_fall = sda_prev & ~sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           start_f <= 1'b0;
      else if (two && sda_fall && sck_s)    start_f <= 1'b1;
      else if (stat_wr && reg_wdata[DW-2])  start_f <= 1'b0;
   end

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  reg_rdata = {{PAD_CT{1'b0}}, ctrl};
         A_DATA:  reg_rdata = sr;
         A_STAT:  reg_rdata = {ovf, start_f, {PAD_ST{1'b0}}, cnt};
         default: reg_rdata = '0;
      endcase
   end

   assign do_o      = three & sr[DW-1];
   assign sck_o     = three & ctrl.clk_sw & sck_lvl;
   assign sda_low_o = two & ~sr[DW-1];
   assign scl_low_o = two & (ctrl.clk_sw ? ~sck_lvl : (ovf | start_f));

   p_shift_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_e && !data_wr) |=> (sr[0] == $past(din)));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (two && !ctrl.clk_sw && ovf) |-> scl_low_o);
   p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (two && sda_fall && sck_s) |=> start_f);
   p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !data_wr) |=> $stable(sr));
endmodule

// File: tb/ussi_core_tb.sv
module ussi_core_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       sw_strobe = 1'b0, sck_i = 1'b0, di_i = 1'b0, sda_i = 1'b1;
   logic       do_o, sck_o, scl_low_o, sda_low_o;
   int         n_cmp = 0, n_bad = 0;
   bit         done = 1'b0;

   always #5ns clk = ~clk;

   ussi_core u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_strobe(sw_strobe),
      .sck_i(sck_i), .di_i(di_i), .sda_i(sda_i), .do_o(do_o), .sck_o(sck_o),
      .scl_low_o(scl_low_o), .sda_low_o(sda_low_o));

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1ns d = reg_rdata;
   endtask

   task automatic pin(input logic v);
      @(negedge clk);
      sck_i = v;
      wait_n(4);
   endtask

   task automatic strobe();
      @(negedge clk);
      sw_strobe = 1'b1;
      @(negedge clk);
      sw_strobe = 1'b0;
   endtask

   function automatic logic [7:0] stat_val(input logic ovf, input logic st, input int c);
      return {ovf, st, 2'b00, 4'(c)};
   endfunction

   // external-clock three-wire transfer, rising shift edge (R2, R5)
   task automatic xfer_ext(input logic [7:0] tx, input logic [7:0] rx);
      logic [7:0] v;
      wr(2'd1, tx);
      wr(2'd2, 8'hC0);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); di_i = rx[7-i];
         wait_n(3);
         chk("R2 do_o bit", {7'd0, do_o}, {7'd0, tx[7-i]});
         pin(1'b1);
         pin(1'b0);
      end
      rd(2'd1, v); chk("R5 received byte", v, rx);
      rd(2'd2, v); chk("R3 overflow after 16 edges", v, stat_val(1'b1, 1'b0, 0));
   endtask

   // software-strobe three-wire transfer (R9)
   task automatic xfer_sw(input logic [7:0] tx, input logic [7:0] rx);
      logic [7:0] v;
      wr(2'd1, tx);
      wr(2'd2, 8'hC0);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); di_i = rx[7-i];
         wait_n(3);
         chk("R9 do_o bit", {7'd0, do_o}, {7'd0, tx[7-i]});
         strobe();
         chk("R9 sck_o high", {7'd0, sck_o}, 8'd1);
         strobe();
         chk("R9 sck_o low", {7'd0, sck_o}, 8'd0);
      end
      rd(2'd1, v); chk("R9 received byte", v, rx);
      rd(2'd2, v); chk("R9 overflow", v, stat_val(1'b1, 1'b0, 0));
   endtask

   initial begin : main
      logic [7:0] v;
      void'($urandom(32'd4711));
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
      rd(2'd1, v); chk("R1 data", v, 8'h00);
      rd(2'd2, v); chk("R1 status", v, 8'h00);
      chk("R1 outputs", {4'd0, do_o, sck_o, scl_low_o, sda_low_o}, 8'h00);

      // R10 disabled: pin edges ignored
      wr(2'd1, 8'h5A);
      pin(1'b1); pin(1'b0); pin(1'b1); pin(1'b0);
      rd(2'd2, v); chk("R10 counter unchanged", v, 8'h00);
      rd(2'd1, v); chk("R10 data unchanged", v, 8'h5A);

      // R4 counter load
      wr(2'd2, 8'h05);
      rd(2'd2, v); chk("R4 counter load", v, stat_val(1'b0, 1'b0, 5));

      // three-wire external, rising shift
      wr(2'd0, 8'h01);
      xfer_ext(8'hA5, 8'h3C);
      xfer_ext(8'h00, 8'hFF);
      xfer_ext(8'hFF, 8'h00);
      for (int k = 0; k < 10; k++) xfer_ext(8'($urandom), 8'($urandom));

      // R4 clear with load while flag set
      wr(2'd2, 8'h83);
      rd(2'd2, v); chk("R4 clear and load", v, stat_val(1'b0, 1'b0, 3));

      // R11 falling shift edge
      wr(2'd0, 8'h09);
      wr(2'd1, 8'h40);
      wr(2'd2, 8'hC0);
      @(negedge clk); di_i = 1'b1;
      pin(1'b1);
      rd(2'd1, v); chk("R11 no shift on rise", v, 8'h40);
      rd(2'd2, v); chk("R11 rise still counts", v, stat_val(1'b0, 1'b0, 1));
      pin(1'b0);
      rd(2'd1, v); chk("R11 shift on fall", v, 8'h81);

      // R9 software strobe
      wr(2'd0, 8'h05);
      xfer_sw(8'hC3, 8'h96);
      for (int k = 0; k < 4; k++) xfer_sw(8'($urandom), 8'($urandom));

      // R6 two-wire data drive
      @(negedge clk); sck_i = 1'b1; sda_i = 1'b1;
      wait_n(4);
      wr(2'd0, 8'h0A);
      wr(2'd2, 8'hC0);
      wr(2'd1, 8'h80);
      chk("R6 sda released for MSB 1", {7'd0, sda_low_o}, 8'd0);
      wr(2'd1, 8'h00);
      chk("R6 sda low for MSB 0", {7'd0, sda_low_o}, 8'd1);

      // R7 slave hold after overflow
      for (int i = 0; i < 15; i++) pin(i[0] ? 1'b1 : 1'b0);
      chk("R7 no hold before overflow", {7'd0, scl_low_o}, 8'd0);
      pin(1'b1);
      rd(2'd2, v); chk("R7 overflow flag", v, stat_val(1'b1, 1'b0, 0));
      chk("R7 hold while flag set", {7'd0, scl_low_o}, 8'd1);
      wr(2'd2, 8'h80);
      chk("R7 released after clear", {7'd0, scl_low_o}, 8'd0);

      // R8 start condition
      @(negedge clk); sda_i = 1'b0;
      wait_n(4);
      rd(2'd2, v); chk("R8 start flag", v, stat_val(1'b0, 1'b1, 0));
      chk("R8 hold on start", {7'd0, scl_low_o}, 8'd1);
      wr(2'd2, 8'h40);
      rd(2'd2, v); chk("R8 start cleared", v, stat_val(1'b0, 1'b0, 0));
      chk("R8 hold released", {7'd0, scl_low_o}, 8'd0);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : watchdog
      #1500us;
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule